// File: doc/BRIEF.md
# Fractional Ratio Clock Divider

This block derives a slower square-wave clock from one of several source clock enables, all of which are synchronous to a single reference clock. The output frequency is the source frequency scaled by a rational factor FRACT/DIVIDE. An accumulator turns each source enable pulse into either a step or a toggle, so every output transition falls on a reference clock edge. The two ratio terms are independent: FRACT runs from 1 to 256 and DIVIDE from 1 to 4096. The lowest output frequency is therefore 1/4096 of the source, and equal terms pass the source rate straight through.

Each pulse on a source enable line counts as one half-period of that source clock. An accumulator adds FRACT on every pulse of the selected source. Whenever the sum reaches DIVIDE, DIVIDE is taken off and the output toggles. Over 2·DIVIDE pulses the output therefore makes 2·FRACT transitions, which gives an average output of f_src·FRACT/DIVIDE.

Software writes both terms through one ratio word, in which each field holds its value minus one. The word lands in a shadow copy and is passed to the running ratio only at an output toggle, so a ratio change never shortens a half-period. Clearing the enable input holds the output low and restarts the phase.

Top module: `ratio_clock_gen`

## Requirements
- R1: After reset the output is low, the accumulator is zero, and the shadow ratio and the running ratio are both FRACT=1, DIVIDE=1.
- R2: Ratio word layout: bits 19:12 hold FRACT-1 and bits 11:0 hold DIVIDE-1. A word is captured on a clock edge where the write strobe is high.
- R3: While enabled, each pulse of the selected source adds FRACT to the accumulator. When the sum is at least DIVIDE, the accumulator keeps the sum minus DIVIDE and the output toggles on that edge. After n pulses from an enable with a constant ratio, the output has made floor(n·FRACT/DIVIDE) transitions.
- R4: With FRACT equal to DIVIDE, the output toggles on every pulse of the selected source.
- R5: With FRACT=1 and DIVIDE=4096, the output toggles once every 4096 pulses.
- R6: A write whose FRACT exceeds its DIVIDE is ignored, and the shadow ratio keeps its previous value.
- R7: While enabled, a new shadow ratio moves to the running ratio only on an edge where the output toggles. On that edge the accumulator restarts at zero. Until then the old ratio keeps timing the output.
- R8: While the enable input is low, the output is held low, the accumulator is cleared and the running ratio follows the shadow. After a re-enable, the first toggle comes after exactly ceil(DIVIDE/FRACT) pulses.
- R9: Only pulses of the source whose index equals the 2-bit select advance the accumulator.
- R10: On an enabled cycle without a selected pulse, the output and the accumulator keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTick | input | 4 | Clock enables, one per selectable source; each pulse is one source half-period |
| srcSel | input | 2 | Index of the source that drives the accumulator |
| outEn | input | 1 | Runs the divider when high; holds the output low when low |
| cfgWe | input | 1 | Write strobe for the ratio word |
| cfgData | input | 20 | Ratio word: FRACT-1 in 19:12, DIVIDE-1 in 11:0 |
| clkOut | output | 1 | Divided square-wave output |

## Verification
The assertions assume that every input is synchronous to the reference clock and holds a defined value from the release of reset onward. They also assume that a source enable may pulse on consecutive cycles without any spacing. Beyond that, the properties make no assumption about how the ratio word, the select and the enable change relative to each other. The stimulus changes all inputs only on falling clock edges. It writes the ratio both while the divider is idle and between toggles while it runs. It uses sources that pulse every cycle, every second cycle, every third cycle and never, and it deliberately offers one illegal ratio word so that the screening path is exercised.

// File: rtl/ratio_clk_pkg.sv
package ratio_clk_pkg;

  // strobes from the control half to the accumulator datapath
  typedef struct packed {
    logic advance;  // a selected source pulse while running
    logic clear;    // divider idle: force output low and zero the phase
    logic restart;  // toggle edge that also adopts a new ratio
  } dpStrobe_t;

endpackage

// File: rtl/ratio_ctrl.sv
module ratio_ctrl
  import ratio_clk_pkg::*;
#(
  parameter int FRACT_W = 8,
  parameter int DIV_W   = 12,
  parameter int NUM_SRC = 4,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CFG_W  = FRACT_W + DIV_W,
  localparam int FA_W   = FRACT_W + 1,
  localparam int DA_W   = DIV_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               outEn,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               wrap,
  output dpStrobe_t          strb,
  output logic [FA_W-1:0]    actFract,
  output logic [DA_W-1:0]    actDiv,
  output logic               selTick
);

  logic [NUM_SRC-1:0] srcHit;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      assign srcHit[g] = srcTick[g] && (srcSel == SEL_W'(g));
    end
  endgenerate

  assign selTick = |srcHit;

  logic [FRACT_W-1:0] wrFract, shFract, runFract;
  logic [DIV_W-1:0]   wrDiv, shDiv, runDiv;
  logic               writeOk, pending, toggleEdge, reload;

  assign wrFract = cfgData[CFG_W-1:DIV_W];
  assign wrDiv   = cfgData[DIV_W-1:0];

  // both fields carry value-1, so the legality compare works on the raw fields
  assign writeOk    = cfgWe && (CFG_W'(wrFract) <= CFG_W'(wrDiv));
  assign pending    = (shFract != runFract) || (shDiv != runDiv);
  assign toggleEdge = outEn && selTick && wrap;
  assign reload     = !outEn || toggleEdge;

  always_comb begin
    strb = '{advance: outEn && selTick,
             clear:   !outEn,
             restart: toggleEdge && pending};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shFract <= '0;
      shDiv   <= '0;
    end else if (writeOk) begin
      shFract <= wrFract;
      shDiv   <= wrDiv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFract <= '0;
      runDiv   <= '0;
    end else if (reload) begin
      runFract <= shFract;
      runDiv   <= shDiv;
    end
  end

  assign actFract = FA_W'(runFract) + FA_W'(1);
  assign actDiv   = DA_W'(runDiv) + DA_W'(1);

endmodule

// File: rtl/ratio_datapath.sv
module ratio_datapath
  import ratio_clk_pkg::*;
#(
  parameter int FRACT_W = 8,
  parameter int DIV_W   = 12,
  localparam int FA_W   = FRACT_W + 1,
  localparam int DA_W   = DIV_W + 1,
  localparam int ACC_W  = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [FA_W-1:0]  fractVal,
  input  logic [DA_W-1:0]  divVal,
  output logic             wrap,
  output logic [ACC_W-1:0] accNow,
  output logic             clkOut
);

  logic [ACC_W-1:0] acc, sum;
  logic             outQ;

  // acc < divVal and fractVal <= divVal keep sum below 2*divVal
  always_comb begin
    sum  = acc + ACC_W'(fractVal);
    wrap = sum >= ACC_W'(divVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc  <= '0;
      outQ <= 1'b0;
    end else if (strb.clear) begin
      acc  <= '0;
      outQ <= 1'b0;
    end else if (strb.advance) begin
      if (wrap) begin
        outQ <= ~outQ;
        acc  <= strb.restart ? '0 : (sum - ACC_W'(divVal));
      end else begin
        acc  <= sum;
      end
    end
  end

  assign accNow = acc;
  assign clkOut = outQ;

endmodule

// File: rtl/ratio_clock_gen.sv
module ratio_clock_gen
  import ratio_clk_pkg::*;
#(
  parameter int FRACT_W = 8,
  parameter int DIV_W   = 12,
  parameter int NUM_SRC = 4,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CFG_W  = FRACT_W + DIV_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               outEn,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgData,
  output logic               clkOut
);

  localparam int FA_W  = FRACT_W + 1;
  localparam int DA_W  = DIV_W + 1;
  localparam int ACC_W = DIV_W + 1;

  dpStrobe_t        strb;
  logic [FA_W-1:0]  actFract;
  logic [DA_W-1:0]  actDiv;
  logic [ACC_W-1:0] accNow;
  logic             wrap;
  logic             selTick;

  ratio_ctrl #(
    .FRACT_W(FRACT_W), .DIV_W(DIV_W), .NUM_SRC(NUM_SRC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .srcSel(srcSel),
    .outEn(outEn), .cfgWe(cfgWe), .cfgData(cfgData), .wrap(wrap),
    .strb(strb), .actFract(actFract), .actDiv(actDiv), .selTick(selTick)
  );

  ratio_datapath #(
    .FRACT_W(FRACT_W), .DIV_W(DIV_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fractVal(actFract),
    .divVal(actDiv), .wrap(wrap), .accNow(accNow), .clkOut(clkOut)
  );

endmodule

// File: rtl/ratio_clock_checker.sv
module ratio_clock_checker #(
  parameter int FRACT_W = 8,
  parameter int DIV_W   = 12,
  localparam int FA_W   = FRACT_W + 1,
  localparam int DA_W   = DIV_W + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            outEn,
  input logic            selTick,
  input logic            wrap,
  input logic            clkOut,
  input logic [DA_W-1:0] accNow,
  input logic [FA_W-1:0] actFract,
  input logic [DA_W-1:0] actDiv
);

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |=> (!clkOut && accNow == '0));

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && !selTick) |=> ($stable(clkOut) && $stable(accNow)));

  assert_toggle_on_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && selTick && wrap) |=> (clkOut != $past(clkOut)));

  assert_acc_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    accNow < actDiv);

  assert_ratio_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    DA_W'(actFract) <= actDiv);

  assert_ratio_steady_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && !(selTick && wrap)) |=> ($stable(actFract) && $stable(actDiv)));

endmodule

bind ratio_clock_gen ratio_clock_checker #(
  .FRACT_W(FRACT_W), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rstN(rstN), .outEn(outEn), .selTick(selTick), .wrap(wrap),
  .clkOut(clkOut), .accNow(accNow), .actFract(actFract), .actDiv(actDiv)
);

// File: tb/test_ratio_clock_gen.sv
`timescale 1ns/1ps
module test_ratio_clock_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcTick = '0;
  logic [1:0]  srcSel = '0;
  logic        outEn = 1'b0;
  logic        cfgWe = 1'b0;
  logic [19:0] cfgData = '0;
  logic        clkOut;

  ratio_clock_gen i_ratio_clock_gen (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .srcSel(srcSel),
    .outEn(outEn), .cfgWe(cfgWe), .cfgData(cfgData), .clkOut(clkOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";

  // source pulse patterns: every cycle, every 2nd, every 3rd, never
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    srcTick[0] = 1'b1;
    srcTick[1] = (cyc % 2 == 0);
    srcTick[2] = (cyc % 3 == 0);
    srcTick[3] = 1'b0;
  end

  // behavioural reference model
  int mAcc, mOut, mF, mD, sF, sD, tickCnt;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAcc = 0; mOut = 0; mF = 1; mD = 1; sF = 1; sD = 1; tickCnt = 0;
    end else begin
      int s, wf, wd;
      if (!outEn) begin
        mAcc = 0; mOut = 0; mF = sF; mD = sD;
      end else if (srcTick[srcSel]) begin
        tickCnt++;
        s = mAcc + mF;
        if (s >= mD) begin
          mOut = 1 - mOut;
          if (sF != mF || sD != mD) begin
            mF = sF; mD = sD; mAcc = 0;
          end else begin
            mAcc = s - mD;
          end
        end else begin
          mAcc = s;
        end
      end
      wf = int'(cfgData[19:12]) + 1;
      wd = int'(cfgData[11:0]) + 1;
      if (cfgWe && wf <= wd) begin
        sF = wf; sD = wd;
      end
    end
  end

  // per-cycle comparison and transition counting
  int   togCnt = 0;
  logic prevOut = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      nChecks++;
      if (clkOut !== 1'(mOut)) begin
        nFails++;
        $display("FAIL %s cycle compare: clkOut=%0b expected=%0d", curReq, clkOut, mOut);
      end
    end
    if (clkOut !== prevOut) togCnt++;
    prevOut = clkOut;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic writeRatio(input int f, input int d);
    step(1);
    cfgWe   = 1'b1;
    cfgData = 20'(((f - 1) << 12) | (d - 1));
    step(1);
    cfgWe   = 1'b0;
  endtask

  task automatic setRun(input bit en, input int sel);
    step(1);
    outEn  = en;
    srcSel = 2'(sel);
  endtask

  bit finished = 0;
  task automatic finishTest();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishTest();
  end

  initial begin
    int t0, k0, cnt;
    step(3);
    rstN = 1'b1;
    step(2);
    // R1: reset state, default ratio 1/1
    check(clkOut == 1'b0, "R1 output low after reset", int'(clkOut), 0);
    setRun(1, 0);
    t0 = togCnt; k0 = tickCnt;
    step(10);
    check(togCnt - t0 == 10, "R1 default ratio 1/1", togCnt - t0, 10);
    setRun(0, 0);

    // R2/R3: ratio 3/7 through the packed word
    curReq = "R3";
    writeRatio(3, 7);
    setRun(1, 0);
    t0 = togCnt; k0 = tickCnt;
    step(700);
    check(tickCnt - k0 == 700, "R3 pulse count", tickCnt - k0, 700);
    check(togCnt - t0 == (tickCnt - k0) * 3 / 7, "R2/R3 transitions for 3/7",
          togCnt - t0, (tickCnt - k0) * 3 / 7);
    setRun(0, 0);

    // R4: equal terms pass through
    curReq = "R4";
    writeRatio(5, 5);
    setRun(1, 0);
    t0 = togCnt;
    step(40);
    check(togCnt - t0 == 40, "R4 pass-through", togCnt - t0, 40);
    setRun(0, 0);

    // R6: FRACT=10 over DIVIDE=4 is refused, 5/5 stays
    curReq = "R6";
    writeRatio(10, 4);
    setRun(1, 0);
    t0 = togCnt;
    step(20);
    check(togCnt - t0 == 20, "R6 illegal write ignored", togCnt - t0, 20);
    setRun(0, 0);

    // R9: only source 2 (every third cycle) counts
    curReq = "R9";
    setRun(1, 2);
    t0 = togCnt; k0 = tickCnt;
    step(30);
    check(togCnt - t0 == 10, "R9 selected source only", togCnt - t0, 10);
    setRun(0, 0);

    // R10: source 3 never pulses, output stays put
    curReq = "R10";
    setRun(1, 3);
    t0 = togCnt;
    step(50);
    check(togCnt - t0 == 0, "R10 no pulse no change", togCnt - t0, 0);
    check(clkOut == 1'b0, "R10 output held", int'(clkOut), 0);
    setRun(0, 0);

    // R5: slowest ratio 1/4096
    curReq = "R5";
    writeRatio(1, 4096);
    setRun(1, 0);
    t0 = togCnt;
    step(8200);
    check(togCnt - t0 == 2, "R5 minimum ratio", togCnt - t0, 2);
    setRun(0, 0);

    // R7: change ratio between toggles
    curReq = "R7";
    writeRatio(1, 50);
    setRun(1, 0);
    cnt = 0;
    while (clkOut == 1'b0 && cnt < 200) begin step(1); cnt++; end
    check(cnt == 50, "R7 first toggle at 1/50", cnt, 50);
    writeRatio(1, 2);
    step(20);
    check(clkOut == 1'b1, "R7 old ratio still active", int'(clkOut), 1);
    cnt = 22;
    while (clkOut == 1'b1 && cnt < 200) begin step(1); cnt++; end
    check(cnt == 50, "R7 second toggle on old ratio", cnt, 50);
    t0 = togCnt;
    step(20);
    check(togCnt - t0 == 10, "R7 new ratio 1/2 after toggle", togCnt - t0, 10);

    // R8: disable holds low, re-enable restarts phase
    curReq = "R8";
    setRun(0, 0);
    step(1);
    check(clkOut == 1'b0, "R8 output low when disabled", int'(clkOut), 0);
    setRun(1, 0);
    t0 = togCnt;
    step(1);
    check(togCnt - t0 == 0, "R8 no toggle after one pulse", togCnt - t0, 0);
    step(1);
    check(togCnt - t0 == 1, "R8 toggle after two pulses", togCnt - t0, 1);
    setRun(0, 0);
    step(2);
    finishTest();
  end

endmodule